// File: doc/BRIEF.md
# Indirect Lookup-Table Register Interface

This block is the host-facing register file of an address lookup table. The table itself is a RAM of `ENTRIES` rows of 96 bits. The host never addresses a row directly. It loads three 32-bit staging words, then writes a command register that holds a row index and a direction bit. With the direction bit set, the staging words are stored into that row. With it clear, the row is copied into the staging words, where the host reads it back.

Next to the table port sit the switch-wide settings that the lookup logic consumes:
- a global control word,
- a prescale value,
- a register of four port masks for unknown-VLAN handling,
- one control word per port.

Two bits of the global control word are commands rather than settings:
- The clear command walks the whole table and zeroes one row per clock.
- The ageout command emits a single-cycle request to the aging engine, which lives elsewhere.

The register bus is a plain synchronous port: address, write strobe, write data and combinational read data. There is no valid/ready pair and no back-pressure. Every write is taken in the cycle it is presented, and `bus_rdata` always reflects the current `bus_addr`. The host must therefore pace table commands itself. While a clear is running, table commands are dropped, so software polls the clear bit before issuing them.

Top module: `lut_regif`

## Requirements
- R1: After reset, the following all read zero and `ageout_req` is low: global control (0x08), prescale (0x10), unknown-VLAN (0x18), table command (0x20), the three staging words and every port control word.
- R2: Offset 0x00 is read-only and returns `REV_MAJOR` in bits 15..8 and `REV_MINOR` in bits 7..0, with zero above. Any word offset not listed in these requirements reads zero and ignores writes.
- R3: The staging words at 0x34, 0x38 and 0x3C are read/write. They hold row bits 95..64, 63..32 and 31..0 respectively.
- R4: A write to 0x20 with bit 31 set stores the three staging words into the row named by the low `IDX_W` bits of the data. Afterwards, 0x20 reads back that index, with bit 31 reading 0.
- R5: A write to 0x20 with bit 31 clear copies the named row into the staging words. The row is readable from the first cycle after the write.
- R6: A table command whose index is `ENTRIES` or above is ignored. No row changes, the staging words are unchanged, and the index read back at 0x20 is unchanged.
- R7: Global control bits 31 (enable), 8 (port-0 unicast flood), 2 (VLAN-aware) and 0 (rate limit) are plain read/write storage. All bits other than these and bits 30 and 29 read zero.
- R8: Writing 1 to global control bit 30 starts a clear. Bit 30 reads 1 for exactly `ENTRIES` cycles after the write, starting at row 0 and advancing one row per cycle. When bit 30 reads 0, every row is zero.
- R9: Table commands written while a clear runs are ignored. Neither the rows nor the staging words change.
- R10: Writing 1 to global control bit 29 drives `ageout_req` high for exactly the one cycle after the write. After that cycle, bit 29 reads 0.
- R11: The unknown-VLAN register holds four 6-bit masks at bits 5..0, 13..8, 21..16 and 29..24. Bits 7..6, 15..14, 23..22 and 31..30 read zero.
- R12: Port p, for p < `PORTS`, has a control word at 0x40+4p with these fields, all other bits reading zero:
  - bits 1..0: port state
  - bit 2: drop untagged
  - bit 3: drop unknown VLAN
  - bit 4: no learning
  - bits 23..16: multicast limit
  - bits 31..24: broadcast limit

  Offsets for p >= `PORTS` read zero and ignore writes.
- R13: The prescale register stores the low `PRESCALE_W` bits of the write data. The bits above read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe, taken in the cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ageout_req | output | 1 | One-cycle request to run an aging pass |

## Verification
The bench builds the block with `ENTRIES` = 12 and `PORTS` = 3.

`ENTRIES` = 12 is not a power of two. This leaves indices 12 to 15 encodable in the 4-bit index field, so the out-of-range drop of R6 can be observed. It also keeps the clear walk short enough that its length is counted cycle by cycle.

`PORTS` = 3 leaves the offset 0x4C, just past the last port, addressable but unbacked, which exercises the upper edge of the port array.

Revision values 2.7 and a 20-bit prescale make the fixed fields of 0x00 and the truncation of 0x10 visible.

// File: rtl/lut_regif_pkg.sv
package lut_regif_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NWORDS  = 3;
  localparam int unsigned ENTRY_W = WORD_W * NWORDS;

  // register map (byte offsets)
  localparam logic [7:0] OFS_ID       = 8'h00;
  localparam logic [7:0] OFS_GCTRL    = 8'h08;
  localparam logic [7:0] OFS_PRESCALE = 8'h10;
  localparam logic [7:0] OFS_UNKVLAN  = 8'h18;
  localparam logic [7:0] OFS_TCMD     = 8'h20;
  localparam logic [7:0] OFS_STAGE0   = 8'h34;
  localparam logic [7:0] OFS_PORT0    = 8'h40;

  // global control bit positions
  localparam int unsigned GC_ENABLE = 31;
  localparam int unsigned GC_CLEAR  = 30;
  localparam int unsigned GC_AGE    = 29;
  localparam int unsigned GC_FLOOD  = 8;
  localparam int unsigned GC_VAWARE = 2;
  localparam int unsigned GC_RLIM   = 0;

  localparam int unsigned TC_COMMIT = 31;

  localparam int unsigned UV_FIELDS = 4;
  localparam int unsigned UV_MASK_W = 6;
  localparam int unsigned UV_STRIDE = 8;

  typedef struct packed {
    logic [7:0] bcast_lim;
    logic [7:0] mcast_lim;
    logic       no_learn;
    logic       drop_unk_vlan;
    logic       drop_untag;
    logic [1:0] state;
  } port_cfg_t;

  function automatic logic [WORD_W-1:0] port_cfg_pack(input port_cfg_t c);
    return {c.bcast_lim, c.mcast_lim, 11'd0, c.no_learn, c.drop_unk_vlan,
            c.drop_untag, c.state};
  endfunction

  function automatic port_cfg_t port_cfg_unpack(input logic [WORD_W-1:0] w);
    port_cfg_t c;
    c.bcast_lim     = w[31:24];
    c.mcast_lim     = w[23:16];
    c.no_learn      = w[4];
    c.drop_unk_vlan = w[3];
    c.drop_untag    = w[2];
    c.state         = w[1:0];
    return c;
  endfunction

endpackage

// File: rtl/lut_table_ram.sv
module lut_table_ram #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned WIDTH   = 96,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/lut_clear_walker.sv
module lut_clear_walker #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             we,
  output logic [IDX_W-1:0] addr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy = busy_q;
  assign we   = busy_q;
  assign addr = cnt_q;

endmodule

// File: rtl/lut_cfg_regs.sv
module lut_cfg_regs
  import lut_regif_pkg::*;
#(
  parameter int unsigned PORTS      = 3,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PRESCALE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              clr_busy,
  output logic              clr_start,
  output logic              ageout_req,
  output logic [WORD_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] A_GCTRL = ADDR_W'(OFS_GCTRL);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFS_PRESCALE);
  localparam logic [ADDR_W-1:0] A_UNKV  = ADDR_W'(OFS_UNKVLAN);

  logic wr_gctrl, wr_presc, wr_unkv;
  assign wr_gctrl = bus_wr && (bus_addr == A_GCTRL);
  assign wr_presc = bus_wr && (bus_addr == A_PRESC);
  assign wr_unkv  = bus_wr && (bus_addr == A_UNKV);

  // ---------------- global control ----------------
  logic en_q, flood_q, vaware_q, rlim_q, age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      flood_q  <= 1'b0;
      vaware_q <= 1'b0;
      rlim_q   <= 1'b0;
      age_q    <= 1'b0;
    end else begin
      age_q <= wr_gctrl && bus_wdata[GC_AGE];
      if (wr_gctrl) begin
        en_q     <= bus_wdata[GC_ENABLE];
        flood_q  <= bus_wdata[GC_FLOOD];
        vaware_q <= bus_wdata[GC_VAWARE];
        rlim_q   <= bus_wdata[GC_RLIM];
      end
    end
  end

  assign clr_start  = wr_gctrl && bus_wdata[GC_CLEAR] && !clr_busy;
  assign ageout_req = age_q;

  logic [WORD_W-1:0] gctrl_rd;
  always_comb begin
    gctrl_rd            = '0;
    gctrl_rd[GC_ENABLE] = en_q;
    gctrl_rd[GC_CLEAR]  = clr_busy;
    gctrl_rd[GC_AGE]    = age_q;
    gctrl_rd[GC_FLOOD]  = flood_q;
    gctrl_rd[GC_VAWARE] = vaware_q;
    gctrl_rd[GC_RLIM]   = rlim_q;
  end

  // ---------------- prescale ----------------
  logic [PRESCALE_W-1:0] presc_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        presc_q <= '0;
    else if (wr_presc) presc_q <= bus_wdata[PRESCALE_W-1:0];
  end

  // ---------------- unknown-VLAN masks ----------------
  logic [WORD_W-1:0] unkv_rd;
  for (genvar f = 0; f < UV_FIELDS; f++) begin : g_uv
    logic [UV_MASK_W-1:0] mask_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_unkv) mask_q <= bus_wdata[f*UV_STRIDE +: UV_MASK_W];
    end
    assign unkv_rd[f*UV_STRIDE +: UV_STRIDE] = UV_STRIDE'(mask_q);
  end

  // ---------------- per-port control ----------------
  logic [WORD_W-1:0] port_rd [PORTS];
  logic [PORTS-1:0]  port_hit;
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(int'(OFS_PORT0) + 4 * p);
    port_cfg_t cfg_q;
    assign port_hit[p] = (bus_addr == A_PORT);
    always_ff @(posedge clk) begin
      if (!rst_n)                    cfg_q <= '0;
      else if (bus_wr && port_hit[p]) cfg_q <= port_cfg_unpack(bus_wdata);
    end
    assign port_rd[p] = port_cfg_pack(cfg_q);
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_data = '0;
    if (bus_addr == A_GCTRL)      rd_data = gctrl_rd;
    else if (bus_addr == A_PRESC) rd_data = WORD_W'(presc_q);
    else if (bus_addr == A_UNKV)  rd_data = unkv_rd;
    else begin
      for (int p = 0; p < int'(PORTS); p++) begin
        if (port_hit[p]) rd_data = port_rd[p];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/lut_regif.sv
module lut_regif
  import lut_regif_pkg::*;
#(
  parameter int unsigned ENTRIES    = 64,
  parameter int unsigned PORTS      = 3,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PRESCALE_W = 20,
  parameter logic [7:0]  REV_MAJOR  = 8'h01,
  parameter logic [7:0]  REV_MINOR  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ageout_req
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_TCMD = ADDR_W'(OFS_TCMD);

  // ---------------- clear walker ----------------
  logic             clr_start, clr_busy, clr_we;
  logic [IDX_W-1:0] clr_addr;

  lut_clear_walker #(.ENTRIES(ENTRIES)) i_walker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (clr_start),
    .busy  (clr_busy),
    .we    (clr_we),
    .addr  (clr_addr)
  );

  // ---------------- table command decode ----------------
  logic [IDX_W-1:0] cmd_idx;
  logic             cmd_in_range, cmd_ok, host_commit, host_fetch;

  assign cmd_idx      = bus_wdata[IDX_W-1:0];
  assign cmd_in_range = ({1'b0, cmd_idx} < (IDX_W+1)'(ENTRIES));
  assign cmd_ok       = bus_wr && (bus_addr == A_TCMD) && !clr_busy && cmd_in_range;
  assign host_commit  = cmd_ok && bus_wdata[TC_COMMIT];
  assign host_fetch   = cmd_ok && !bus_wdata[TC_COMMIT];

  // ---------------- staging words and index ----------------
  logic [ENTRY_W-1:0] entry_q;
  logic [IDX_W-1:0]   tidx_q;
  logic [ENTRY_W-1:0] ram_rdata, ram_wdata;
  logic [IDX_W-1:0]   ram_addr;
  logic               ram_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q <= '0;
      tidx_q  <= '0;
    end else begin
      if (cmd_ok) tidx_q <= cmd_idx;
      if (host_fetch) begin
        entry_q <= ram_rdata;
      end else if (bus_wr) begin
        for (int k = 0; k < int'(NWORDS); k++) begin
          if (bus_addr == ADDR_W'(int'(OFS_STAGE0) + 4 * k))
            entry_q[ENTRY_W-1-WORD_W*k -: WORD_W] <= bus_wdata;
        end
      end
    end
  end

  // ---------------- table RAM, shared port ----------------
  assign ram_we    = clr_we | host_commit;
  assign ram_addr  = clr_busy ? clr_addr : cmd_idx;
  assign ram_wdata = clr_busy ? '0 : entry_q;

  lut_table_ram #(.ENTRIES(ENTRIES), .WIDTH(ENTRY_W)) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  // ---------------- configuration registers ----------------
  logic [WORD_W-1:0] cfg_rd;

  lut_cfg_regs #(
    .PORTS      (PORTS),
    .ADDR_W     (ADDR_W),
    .PRESCALE_W (PRESCALE_W)
  ) i_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .clr_busy   (clr_busy),
    .clr_start  (clr_start),
    .ageout_req (ageout_req),
    .rd_data    (cfg_rd)
  );

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = cfg_rd;
    if (bus_addr == A_ID)   bus_rdata = {16'd0, REV_MAJOR, REV_MINOR};
    if (bus_addr == A_TCMD) bus_rdata = WORD_W'(tidx_q);
    for (int k = 0; k < int'(NWORDS); k++) begin
      if (bus_addr == ADDR_W'(int'(OFS_STAGE0) + 4 * k))
        bus_rdata = entry_q[ENTRY_W-1-WORD_W*k -: WORD_W];
    end
  end

endmodule

// File: rtl/lut_regif_chk.sv
module lut_regif_chk
  import lut_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               ageout_req,
  input logic               clr_busy,
  input logic [IDX_W-1:0]   clr_addr,
  input logic [ENTRY_W-1:0] entry_q
);

  logic age_wr, clr_wr, tcmd_wr;
  assign age_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_GCTRL)) && bus_wdata[GC_AGE];
  assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_GCTRL)) && bus_wdata[GC_CLEAR];
  assign tcmd_wr = bus_wr && (bus_addr == ADDR_W'(OFS_TCMD));

  AST_AGE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    age_wr |=> ageout_req); // R10

  AST_AGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ageout_req && !age_wr) |=> !ageout_req); // R10

  AST_CLEAR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !clr_busy) |=> clr_busy); // R8

  AST_CLEAR_FROM_ROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_busy) |-> (clr_addr == '0)); // R8

  AST_CLEAR_ONE_ROW_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (!clr_busy || clr_addr == IDX_W'($past(clr_addr) + 1'b1))); // R8

  AST_NO_TABLE_CMD_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && tcmd_wr) |=> $stable(entry_q)); // R9

  AST_GCTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_GCTRL)) |-> ((bus_rdata & 32'h1FFF_FEFA) == 32'd0)); // R7

  AST_UNKV_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_UNKVLAN)) |-> ((bus_rdata & 32'hC0C0_C0C0) == 32'd0)); // R11

  logic unused_chk;
  assign unused_chk = ^{bus_wdata[31], bus_wdata[28:0]};

endmodule

bind lut_regif lut_regif_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .ageout_req (ageout_req),
  .clr_busy   (clr_busy),
  .clr_addr   (clr_addr),
  .entry_q    (entry_q)
);

// File: tb/test_lut_regif.sv
module test_lut_regif;

  localparam int unsigned ENTRIES = 12;
  localparam int unsigned PORTS   = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ageout_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lut_regif #(
    .ENTRIES    (ENTRIES),
    .PORTS      (PORTS),
    .ADDR_W     (8),
    .PRESCALE_W (20),
    .REV_MAJOR  (8'h02),
    .REV_MINOR  (8'h07)
  ) i_lut_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ageout_req (ageout_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic stage(input logic [95:0] v);
    wr(8'h34, v[95:64]);
    wr(8'h38, v[63:32]);
    wr(8'h3C, v[31:0]);
  endtask

  task automatic expect_stage(input string req, input logic [95:0] v);
    expect_reg(req, 8'h34, v[95:64]);
    expect_reg(req, 8'h38, v[63:32]);
    expect_reg(req, 8'h3C, v[31:0]);
  endtask

  task automatic t_reset;
    expect_reg("R1 gctrl", 8'h08, 32'h0);
    expect_reg("R1 prescale", 8'h10, 32'h0);
    expect_reg("R1 unkvlan", 8'h18, 32'h0);
    expect_reg("R1 tcmd", 8'h20, 32'h0);
    expect_stage("R1 stage", 96'h0);
    for (int p = 0; p < int'(PORTS); p++) expect_reg("R1 port", 8'(8'h40 + 4 * p), 32'h0);
    check("R1 ageout_req", {31'd0, ageout_req}, 32'h0);
    expect_reg("R2 id", 8'h00, 32'h0000_0207);
  endtask

  task automatic t_map;
    wr(8'h00, 32'hFFFF_FFFF);
    expect_reg("R2 id read-only", 8'h00, 32'h0000_0207);
    wr(8'h04, 32'h1234_5678);
    expect_reg("R2 unmapped", 8'h04, 32'h0);
    wr(8'h2C, 32'hDEAD_BEEF);
    expect_reg("R2 unmapped gap", 8'h2C, 32'h0);
  endtask

  task automatic t_stage_rw;
    stage(96'h0102_0304_A5A5_5A5A_F0E1_D2C3);
    expect_stage("R3 staging rw", 96'h0102_0304_A5A5_5A5A_F0E1_D2C3);
  endtask

  task automatic t_commit_fetch;
    stage(96'h1111_1111_2222_2222_3333_3333);
    wr(8'h20, 32'h8000_0005);
    expect_reg("R4 index readback", 8'h20, 32'h0000_0005);
    stage(96'hAAAA_0000_BBBB_0000_CCCC_0000);
    wr(8'h20, 32'h8000_000B);
    stage(96'h0);
    wr(8'h20, 32'h8000_0000);
    stage(96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
    wr(8'h20, 32'h0000_0005);
    expect_stage("R5 fetch row 5", 96'h1111_1111_2222_2222_3333_3333);
    wr(8'h20, 32'h0000_000B);
    expect_stage("R5 fetch last row", 96'hAAAA_0000_BBBB_0000_CCCC_0000);
    wr(8'h20, 32'h0000_0000);
    expect_stage("R4 commit row 0", 96'h0);
    expect_reg("R4 index readback fetch", 8'h20, 32'h0000_0000);
  endtask

  task automatic t_range;
    wr(8'h20, 32'h0000_0005);
    wr(8'h20, 32'h0000_000D);
    expect_stage("R6 fetch out of range", 96'h1111_1111_2222_2222_3333_3333);
    expect_reg("R6 index unchanged", 8'h20, 32'h0000_0005);
    stage(96'h9999_9999_9999_9999_9999_9999);
    wr(8'h20, 32'h8000_000C);
    wr(8'h20, 32'h0000_0005);
    expect_stage("R6 commit out of range", 96'h1111_1111_2222_2222_3333_3333);
  endtask

  task automatic t_gctrl;
    wr(8'h08, 32'h8000_0105);
    expect_reg("R7 fields set", 8'h08, 32'h8000_0105);
    wr(8'h08, 32'h1FFF_FEFA);
    expect_reg("R7 reserved", 8'h08, 32'h0);
  endtask

  task automatic t_ageout;
    logic [31:0] d;
    wr(8'h08, 32'h2000_0004);
    #1;
    check("R10 pulse high", {31'd0, ageout_req}, 32'h1);
    @(negedge clk);
    #1;
    check("R10 pulse ends", {31'd0, ageout_req}, 32'h0);
    rd(8'h08, d);
    check("R10 bit reads 0", d, 32'h0000_0004);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    int cyc;
    stage(96'h5555_5555_6666_6666_7777_7777);
    wr(8'h20, 32'h8000_0007);
    wr(8'h20, 32'h8000_000B);
    wr(8'h08, 32'h4000_0000);
    cyc = 0;
    rd(8'h08, d);
    while (d[30] && cyc < 100) begin
      cyc++;
      @(negedge clk);
      rd(8'h08, d);
    end
    check("R8 clear length", cyc, ENTRIES);
    wr(8'h20, 32'h0000_0007);
    expect_stage("R8 row 7 zero", 96'h0);
    wr(8'h20, 32'h0000_000B);
    expect_stage("R8 row 11 zero", 96'h0);
  endtask

  task automatic t_clear_block;
    logic [31:0] d;
    int cyc;
    stage(96'hCAFE_0001_CAFE_0002_CAFE_0003);
    wr(8'h08, 32'h4000_0000);
    wr(8'h20, 32'h0000_0003);
    expect_stage("R9 fetch ignored", 96'hCAFE_0001_CAFE_0002_CAFE_0003);
    repeat (2) @(negedge clk);
    wr(8'h20, 32'h8000_0000);
    cyc = 0;
    rd(8'h08, d);
    while (d[30] && cyc < 100) begin
      cyc++;
      @(negedge clk);
      rd(8'h08, d);
    end
    wr(8'h20, 32'h0000_0000);
    expect_stage("R9 commit ignored", 96'h0);
  endtask

  task automatic t_unkv;
    wr(8'h18, 32'hFFFF_FFFF);
    expect_reg("R11 masks", 8'h18, 32'h3F3F_3F3F);
    wr(8'h18, 32'h0102_0304);
    expect_reg("R11 values", 8'h18, 32'h0102_0304);
  endtask

  task automatic t_ports;
    wr(8'h48, 32'hFFFF_FFFF);
    expect_reg("R12 port2 fields", 8'h48, 32'hFFFF_001F);
    expect_reg("R12 port0 untouched", 8'h40, 32'h0);
    wr(8'h44, 32'hA55A_0013);
    expect_reg("R12 port1", 8'h44, 32'hA55A_0013);
    wr(8'h4C, 32'hFFFF_FFFF);
    expect_reg("R12 beyond ports", 8'h4C, 32'h0);
  endtask

  task automatic t_prescale;
    wr(8'h10, 32'hFFFF_FFFF);
    expect_reg("R13 prescale width", 8'h10, 32'h000F_FFFF);
    wr(8'h10, 32'h0001_2345);
    expect_reg("R13 prescale value", 8'h10, 32'h0001_2345);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    bus_addr  = 8'h0;
    bus_wr    = 1'b0;
    bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_stage_rw();
    t_commit_fetch();
    t_range();
    t_gctrl();
    t_ageout();
    t_clear();
    t_clear_block();
    t_unkv();
    t_ports();
    t_prescale();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule